// File: doc/BRIEF.md
# RS(255,239) Framed Syndrome Calculator

This block takes a byte stream of Reed-Solomon (255,239) codewords and works out the sixteen syndromes of each one over GF(256). The field is built on the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D). The generator roots are alpha^0 through alpha^15, so syndrome S_i is the received polynomial evaluated at alpha^i. The first byte of a codeword carries the highest power and the last byte is the constant term.

A start strobe marks the first byte. The 254 bytes that follow arrive on the next consecutive clocks. Blocks may arrive back-to-back or with idle clocks between them. The block raises a one-cycle valid pulse once a full codeword has been absorbed. During that pulse it also shows an error-free flag when all sixteen syndromes are zero. The decode stages downstream (error locator, root search, magnitudes) read the syndromes from here. Data buffering is handled outside this block.

Top module: `rs_syndrome_calc`

## Requirements
- R1: At valid, `synd_o[8*i+7:8*i]` holds S_i = XOR over j=0..254 of b_j * alpha^(i*(254-j)), for i = 0..15. Here b_0 is the byte sampled with start, alpha = 0x02, and field products are reduced by 0x11D.
- R2: If the first byte is sampled at rising edge E, then `synd_valid_o` is high for exactly the cycle after edge E+255. This holds for every block of 255 consecutive bytes.
- R3: `synd_valid_o` is never high on two consecutive cycles.
- R4: Blocks separated by any number of idle clocks, including none, each yield their own correct syndromes.
- R5: `zero_synd_o` is high only while `synd_valid_o` is high, and then only if all sixteen syndromes are zero. A valid codeword raises it; a codeword with one corrupted byte does not.
- R6: After the valid pulse, `synd_o` holds its values until the first byte of the next block has been absorbed.
- R7: Bytes that arrive after the 255th byte without a new start are ignored. They change no syndrome and cause no further valid pulse.
- R8: A start that comes before the current block is complete discards the partial block. No valid pulse is produced for the discarded bytes, and the new block is computed from its own first byte.
- R9: Synchronous active-low reset clears `synd_o` to zero and holds `synd_valid_o` and `zero_synd_o` low. A block that is cut off by reset produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | High with the first byte of a block |
| data_i | input | 8 | Received codeword byte |
| synd_o | output | 128 | Syndromes, S_i in bits [8i+7:8i] |
| synd_valid_o | output | 1 | One-cycle pulse: syndromes complete |
| zero_synd_o | output | 1 | All syndromes zero, qualified by valid |

## Verification
The assertions check on every cycle that valid is a single-cycle pulse that closes an active block. They also check that the zero flag never appears without valid, that the syndrome registers stay still whenever no byte is being absorbed, and that reset clears the outputs. Only the bench scenarios can show that the syndrome values are correct and that the pulse lands exactly 256 cycles after start. The same applies to ignoring stray bytes between gaps, discarding an aborted block, and the correct zero flag for real encoded codewords, both clean and corrupted.

// File: rtl/rs_synd_pkg.sv
// Package: GF(256) helpers for the syndrome calculator.
// Assumes the field reduction polynomial 0x11D and alpha = 0x02.
package rs_synd_pkg;
    localparam int SYM_W = 8;
    localparam logic [SYM_W-1:0] FIELD_POLY_LO = 8'h1D;

    typedef logic [SYM_W-1:0] sym_t;

    // Multiply a field element by alpha (one shift with reduction).
    function automatic sym_t gf_mul_alpha(input sym_t x);
        return {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? FIELD_POLY_LO : '0);
    endfunction

    // Multiply a field element by alpha^n for a constant n.
    function automatic sym_t gf_mul_alpha_pow(input sym_t x, input int n);
        sym_t r;
        r = x;
        for (int k = 0; k < n; k++) begin
            r = gf_mul_alpha(r);
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_synd_input_reg.sv
// Module: input register stage.
// Samples the start strobe and data byte on every rising edge so the
// accumulators see registered inputs. Start is cleared by reset.
module rs_synd_input_reg
    import rs_synd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  sym_t data_i,
    output logic start_q,
    output sym_t data_q
);
    // Capture the inputs; reset drops any pending start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            data_q  <= '0;
        end else begin
            start_q <= start_i;
            data_q  <= data_i;
        end
    end
endmodule

// File: rtl/rs_synd_framer.sv
// Module: block framer.
// Tracks how many bytes of the current block have been absorbed and
// decides, per cycle, whether the accumulators load, shift or hold.
// Assumes start_q marks byte one; bytes past BLOCK_LEN are dropped.
module rs_synd_framer #(
    parameter int BLOCK_LEN = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_q,
    output logic load_o,
    output logic shift_o,
    output logic active_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(BLOCK_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLOCK_LEN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;

    // Decide the accumulator action for this cycle.
    always_comb begin
        load_o   = start_q;
        shift_o  = active_q && !start_q;
        active_o = active_q;
    end

    // Count absorbed bytes and flag the closing byte of the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= shift_o && (cnt_q == LAST_CNT);
            if (start_q) begin
                cnt_q    <= CNT_W'(1);
                active_q <= 1'b1;
            end else if (shift_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == LAST_CNT) begin
                    active_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rs_synd_cell.sv
// Module: one syndrome accumulator.
// Evaluates the received polynomial at alpha^ROOT_POW by Horner's rule,
// highest-degree byte first. A load replaces the sum with the byte.
module rs_synd_cell
    import rs_synd_pkg::*;
#(
    parameter int ROOT_POW = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_i,
    input  sym_t data_i,
    output sym_t synd_o
);
    sym_t acc_q;

    // Load on block start, multiply-and-add on later bytes, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= data_i;
        end else if (shift_i) begin
            acc_q <= gf_mul_alpha_pow(acc_q, ROOT_POW) ^ data_i;
        end
    end

    assign synd_o = acc_q;
endmodule

// File: rtl/rs_syndrome_calc.sv
// Module: framed RS(255,239) syndrome calculator (top).
// Registers the inputs, frames each block by its start strobe and runs
// NUM_ROOTS Horner accumulators in parallel. Syndromes stay on synd_o
// until the next block loads; valid pulses one cycle per full block.
module rs_syndrome_calc
    import rs_synd_pkg::*;
#(
    parameter int BLOCK_LEN = 255,
    parameter int NUM_ROOTS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [SYM_W-1:0]           data_i,
    output logic [NUM_ROOTS*SYM_W-1:0] synd_o,
    output logic                       synd_valid_o,
    output logic                       zero_synd_o
);
    logic start_q;
    sym_t data_q;
    logic load;
    logic shift;
    logic active;
    logic done;

    rs_synd_input_reg u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .data_i  (data_i),
        .start_q (start_q),
        .data_q  (data_q)
    );

    rs_synd_framer #(.BLOCK_LEN(BLOCK_LEN)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_q  (start_q),
        .load_o   (load),
        .shift_o  (shift),
        .active_o (active),
        .done_o   (done)
    );

    for (genvar i = 0; i < NUM_ROOTS; i++) begin : g_cell
        rs_synd_cell #(.ROOT_POW(i)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .shift_i (shift),
            .data_i  (data_q),
            .synd_o  (synd_o[i*SYM_W +: SYM_W])
        );
    end

    // Qualify the all-zero indication with the completion pulse.
    always_comb begin
        synd_valid_o = done;
        zero_synd_o  = done && (synd_o == '0);
    end
endmodule

// File: rtl/rs_syndrome_calc_chk.sv
// Module: assertion checker for rs_syndrome_calc, attached by bind.
// Watches the ports plus the framer's active flag and the registered start.
module rs_syndrome_calc_chk #(
    parameter int NUM_ROOTS = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_q,
    input logic                   active,
    input logic [NUM_ROOTS*8-1:0] synd,
    input logic                   valid,
    input logic                   zero
);
    // R3: completion is a single-cycle pulse.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R2: a pulse only closes a block that was being absorbed.
    a_r2_closes_block: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(active) && !active));

    // R5: the zero flag never appears without the valid pulse.
    a_r5_zero_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> valid);

    // R6 / R7: with no byte being absorbed the syndromes do not move.
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start_q) |=> $stable(synd));

    // R9: reset clears the syndromes and the flags.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (synd == '0 && !valid && !zero));
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(.NUM_ROOTS(NUM_ROOTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_q (start_q),
    .active  (active),
    .synd    (synd_o),
    .valid   (synd_valid_o),
    .zero    (zero_synd_o)
);

// File: tb/rs_syndrome_calc_tb.sv
// Bench for rs_syndrome_calc: random and directed blocks, reference
// syndromes from a power table, codewords from a bench-side encoder.
module rs_syndrome_calc_tb;
    localparam int N = 255;
    localparam int R = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [7:0]   data_i = '0;
    logic [127:0] synd_o;
    logic         synd_valid_o;
    logic         zero_synd_o;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;
    logic        prev_valid = 1'b0;

    logic [7:0]   blk  [0:N-1];
    logic [7:0]   alog [0:N-1];
    logic [7:0]   gen  [0:R];
    logic [127:0] q_synd [$];
    int unsigned  q_cyc  [$];

    rs_syndrome_calc u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .data_i       (data_i),
        .synd_o       (synd_o),
        .synd_valid_o (synd_valid_o),
        .zero_synd_o  (zero_synd_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = '0;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p = p ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [127:0] ref_synd();
        logic [127:0] s = '0;
        for (int i = 0; i < R; i++) begin
            logic [7:0] acc = '0;
            for (int j = 0; j < N; j++) begin
                acc = acc ^ gf_mul(blk[j], alog[(i * (N - 1 - j)) % N]);
            end
            s[8*i +: 8] = acc;
        end
        return s;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Systematic encode: random info bytes 0..238, parity in 239..254.
    task automatic make_codeword();
        logic [7:0] p [0:R-1];
        logic [7:0] fb;
        for (int k = 0; k < R; k++) p[k] = '0;
        for (int j = 0; j < N - R; j++) begin
            blk[j] = 8'($urandom);
            fb = blk[j] ^ p[R-1];
            for (int k = R - 1; k > 0; k--) p[k] = p[k-1] ^ gf_mul(fb, gen[k]);
            p[0] = gf_mul(fb, gen[0]);
        end
        for (int k = 0; k < R; k++) blk[N - R + k] = p[R - 1 - k];
    endtask

    // Drive nbytes of blk, then gap idle clocks of stray data.
    task automatic send_block(input int nbytes, input int gap, input bit hold_chk);
        logic [127:0] exp;
        exp = ref_synd();
        for (int j = 0; j < nbytes; j++) begin
            @(negedge clk);
            if (j == 0 && nbytes == N) begin
                q_synd.push_back(exp);
                q_cyc.push_back(cyc + 256);
            end
            start_i = (j == 0);
            data_i  = blk[j];
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            start_i = 1'b0;
            data_i  = 8'($urandom);
            if (hold_chk && g >= 2 && g == gap - 1)
                chk("R6/R7 hold after block", synd_o, exp);
        end
    endtask

    // Monitor: timing, values and zero flag of each completion pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (synd_valid_o && prev_valid) chk("R3 double pulse", 1, 0);
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                chk("R2 valid timing", 128'(synd_valid_o), 1);
                chk("R1 syndromes", synd_o, q_synd[0]);
                chk("R5 zero flag", 128'(zero_synd_o), 128'(q_synd[0] == '0));
                void'(q_synd.pop_front());
                void'(q_cyc.pop_front());
            end else if (synd_valid_o) begin
                chk("R7/R8 unexpected valid", 1, 0);
            end
            if (zero_synd_o && !synd_valid_o) chk("R5 zero without valid", 1, 0);
        end
        prev_valid <= synd_valid_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        alog[0] = 8'h01;
        for (int k = 1; k < N; k++) alog[k] = gf_mul(alog[k-1], 8'h02);
        for (int k = 0; k <= R; k++) gen[k] = (k == 0) ? 8'h01 : 8'h00;
        for (int i = 0; i < R; i++)
            for (int k = R; k >= 0; k--)
                gen[k] = gf_mul(gen[k], alog[i]) ^ ((k > 0) ? gen[k-1] : 8'h00);

        // R9: reset state.
        repeat (3) @(negedge clk);
        chk("R9 reset synd", synd_o, '0);
        chk("R9 reset valid", 128'({synd_valid_o, zero_synd_o}), 0);
        rst_n = 1'b1;

        // R5: all-zero block, then encoded codeword.
        for (int j = 0; j < N; j++) blk[j] = '0;
        send_block(N, 6, 1);
        make_codeword();
        send_block(N, 6, 1);
        // R5: one corrupted byte.
        make_codeword();
        blk[37] = blk[37] ^ 8'h5A;
        send_block(N, 6, 1);
        // R1: all 0xFF.
        for (int j = 0; j < N; j++) blk[j] = 8'hFF;
        send_block(N, 5, 1);
        // R4: back-to-back blocks.
        for (int b = 0; b < 3; b++) begin
            for (int j = 0; j < N; j++) blk[j] = 8'($urandom);
            send_block(N, 0, 0);
        end
        // R4 / R7: random gaps with stray bytes.
        for (int b = 0; b < 10; b++) begin
            if (b % 3 == 0) make_codeword();
            else for (int j = 0; j < N; j++) blk[j] = 8'($urandom);
            send_block(N, 1 + int'($urandom % 20), 1);
        end
        // R8: aborted partial block followed by a full one.
        for (int j = 0; j < N; j++) blk[j] = 8'($urandom);
        send_block(100, 0, 0);
        for (int j = 0; j < N; j++) blk[j] = 8'($urandom);
        send_block(N, 6, 1);
        // R9: reset cuts a block short.
        send_block(60, 0, 0);
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 mid-block reset synd", synd_o, '0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        make_codeword();
        send_block(N, 6, 1);

        chk("R2 all pulses seen", 128'(q_cyc.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule